// File: doc/BRIEF.md
# Crossing-Indexed Hit Ring Buffer

This block keeps zero-suppressed hit words from a front-end readout chip and sorts them by beam crossing. A beam-clock strobe, carrying an 8-bit crossing tag, opens a new slot in a ring of 64 slots. Every parallel hit word that arrives while that slot is open is written into it, up to 8 hits. The hit memory is dual-ported, so capture never stalls. It is never cleared. The only thing that says how many of a slot's words are valid is that slot's fill counter, and the counter is zeroed at the moment the slot is re-entered.

A trigger request names a crossing tag. The readout sequencer searches the 64 stored tags for it. If the tag appears more than once, the newest slot with that tag wins. The sequencer then streams that slot's counted hits in arrival order over a valid/ready handshake. At the end it raises a one-cycle completion pulse together with the hit count, an overflow flag and a miss flag. While a readout is running, new hits and strobes are still captured.

Top module: `xing_hit_buffer`

## Requirements
- R1: After reset, `trig_ready` is 1 and `out_valid` and `rsp_done` are 0. Hits that arrive before the first beam-clock strobe are discarded, so no slot holds them.
- R2: A request for a stored tag streams that slot's hits on `out_data`, oldest first. Exactly `rsp_count` words are delivered, and `out_last` is 1 only on the final one.
- R3: A slot keeps at most 8 hits. A ninth or later hit in the same crossing is dropped. The response then reports `rsp_count` = 8 and `rsp_overflow` = 1. Exactly 8 hits report 8 with `rsp_overflow` = 0.
- R4: A hit that arrives in the same cycle as a beam-clock strobe becomes hit 0 of the newly opened slot.
- R5: Only the 64 most recent crossings can be found. The oldest of those 64 is still found. Once one more strobe arrives, it misses.
- R6: A request whose tag is in no live slot completes with `rsp_miss` = 1 and `rsp_count` = 0, and sends no words.
- R7: A slot that is re-entered starts empty: hits left over from the crossing it held 64 strobes earlier are never returned. A crossing with no hits completes with `rsp_count` = 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values.
- R9: Hits and strobes that arrive while a readout is stalled or in progress are stored and can be read back later.
- R10: When the same tag is held by two live slots, a request returns the more recent crossing.
- R11: While a request is being served, `trig_ready` is 0 and any request presented then is ignored. It produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_strobe | input | 1 | Beam-clock strobe; opens a new slot |
| bc_tag | input | 8 | Crossing tag recorded in the new slot |
| hit_valid | input | 1 | Hit word present this cycle |
| hit_data | input | 18 | Deserialized hit word |
| trig_valid | input | 1 | Readout request present |
| trig_tag | input | 8 | Crossing tag requested |
| trig_ready | output | 1 | Sequencer idle; request accepted when valid |
| out_valid | output | 1 | Hit word offered on `out_data` |
| out_ready | input | 1 | Consumer takes the offered word |
| out_data | output | 18 | Stored hit word |
| out_last | output | 1 | Offered word is the slot's final hit |
| rsp_done | output | 1 | One-cycle pulse at the end of a request |
| rsp_count | output | 4 | Hits in the served slot, 0 to 8 |
| rsp_overflow | output | 1 | Served slot dropped at least one hit |
| rsp_miss | output | 1 | Requested tag was not found |

## Verification
The assertions check the following on every cycle:
- a dropped hit never writes memory;
- a hit arriving with a strobe is written to word 0 of the next slot;
- nothing is written before the first slot opens;
- a stalled output holds still;
- the sequencer refuses requests while it is streaming;
- the number of words delivered equals the reported count, and a miss delivers none.

Which words come back for which tag can only be shown by the bench's scenarios. That covers the arrival order, the 64-crossing window edge, lazy clearing of recycled slots, newest-wins selection on duplicate tags, and capture during a stalled readback. The bench sweeps all 64 slots with fill levels from 0 to 9 and computes each expected word from the crossing number and the hit index.

// File: rtl/xhb_pkg.sv
package xhb_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOOK,
    SQ_READ,
    SQ_SHOW
  } sq_state_e;

endpackage

// File: rtl/xhb_slot_store.sv
module xhb_slot_store #(
  parameter int SLOT_W = 6,
  parameter int HIT_W  = 3,
  parameter int TAG_W  = 8,
  localparam int SLOTS = 1 << SLOT_W,
  localparam int AW    = SLOT_W + HIT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bc_strobe,
  input  logic [TAG_W-1:0]            bc_tag,
  input  logic                        hit_valid,
  output logic [SLOT_W-1:0]           wr_slot,
  output logic                        slot_open,
  output logic                        hit_accept,
  output logic                        hit_drop,
  output logic                        we,
  output logic [AW-1:0]               wa,
  output logic [SLOTS-1:0][TAG_W-1:0] tags,
  output logic [SLOTS-1:0]            used,
  input  logic [SLOT_W-1:0]           q_slot,
  output logic [HIT_W:0]              q_count,
  output logic                        q_lost
);

  // fill = {full, count}: 0..2**HIT_W in plain binary
  logic [HIT_W:0] fill [SLOTS];
  logic           lost [SLOTS];

  logic [SLOT_W-1:0] next_slot;
  logic [SLOT_W-1:0] cur_slot;
  logic [HIT_W:0]    cur_fill;
  logic              can_take;

  function automatic logic [HIT_W:0] bump(input logic [HIT_W:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic [AW-1:0] hit_addr(input logic [SLOT_W-1:0] s,
                                             input logic [HIT_W-1:0]  i);
    return {s, i};
  endfunction

  assign next_slot  = wr_slot + 1'b1;
  assign cur_slot   = bc_strobe ? next_slot : wr_slot;
  assign cur_fill   = bc_strobe ? '0 : fill[wr_slot];
  assign can_take   = bc_strobe || slot_open;
  assign hit_accept = hit_valid && can_take && !cur_fill[HIT_W];
  assign hit_drop   = hit_valid && can_take && cur_fill[HIT_W];
  assign we         = hit_accept;
  assign wa         = hit_addr(cur_slot, cur_fill[HIT_W-1:0]);

  assign q_count = fill[q_slot];
  assign q_lost  = lost[q_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot   <= '1;
      slot_open <= 1'b0;
      used      <= '0;
    end else if (bc_strobe) begin
      wr_slot         <= next_slot;
      slot_open       <= 1'b1;
      used[next_slot] <= 1'b1;
    end
  end

  // Per-slot bookkeeping is recycled lazily on slot entry; no reset needed.
  always_ff @(posedge clk) begin
    if (bc_strobe) begin
      tags[next_slot] <= bc_tag;
      fill[next_slot] <= {{HIT_W{1'b0}}, hit_accept};
      lost[next_slot] <= 1'b0;
    end else begin
      if (hit_accept) fill[wr_slot] <= bump(fill[wr_slot]);
      if (hit_drop)   lost[wr_slot] <= 1'b1;
    end
  end

endmodule

// File: rtl/xhb_tag_search.sv
module xhb_tag_search #(
  parameter int SLOT_W = 6,
  parameter int TAG_W  = 8,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic [SLOTS-1:0][TAG_W-1:0] tags,
  input  logic [SLOTS-1:0]            used,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [TAG_W-1:0]            key,
  output logic                        found,
  output logic [SLOT_W-1:0]           found_slot
);

  function automatic logic [SLOT_W-1:0] slot_at_age(input logic [SLOT_W-1:0] head,
                                                    input int unsigned       age);
    return head - SLOT_W'(age);
  endfunction

  // Walk from oldest to newest; the last match seen is the newest one.
  always_comb begin
    found      = 1'b0;
    found_slot = '0;
    for (int age = SLOTS - 1; age >= 0; age--) begin
      logic [SLOT_W-1:0] s;
      s = slot_at_age(wr_slot, age);
      if (used[s] && tags[s] == key) begin
        found      = 1'b1;
        found_slot = s;
      end
    end
  end

endmodule

// File: rtl/xhb_hit_ram.sv
module xhb_hit_ram #(
  parameter int AW = 9,
  parameter int DW = 18,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/xhb_readout.sv
module xhb_readout
  import xhb_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int HIT_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DW     = 18,
  localparam int AW    = SLOT_W + HIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [TAG_W-1:0]  trig_tag,
  output logic              trig_ready,
  output logic [TAG_W-1:0]  key,
  input  logic              found,
  input  logic [SLOT_W-1:0] found_slot,
  output logic [SLOT_W-1:0] q_slot,
  input  logic [HIT_W:0]    q_count,
  input  logic              q_lost,
  output logic              re,
  output logic [AW-1:0]     ra,
  input  logic [DW-1:0]     rd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  output logic              rsp_done,
  output logic [HIT_W:0]    rsp_count,
  output logic              rsp_overflow,
  output logic              rsp_miss
);

  sq_state_e         state;
  logic [SLOT_W-1:0] slot_r;
  logic [HIT_W:0]    idx;

  function automatic logic is_final(input logic [HIT_W:0] i, input logic [HIT_W:0] n);
    return (i + 1'b1) == n;
  endfunction

  assign trig_ready = (state == SQ_IDLE);
  assign q_slot     = found_slot;
  assign re         = (state == SQ_READ);
  assign ra         = {slot_r, idx[HIT_W-1:0]};
  assign out_valid  = (state == SQ_SHOW);
  assign out_data   = rd;
  assign out_last   = out_valid && is_final(idx, rsp_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SQ_IDLE;
      key          <= '0;
      slot_r       <= '0;
      idx          <= '0;
      rsp_done     <= 1'b0;
      rsp_count    <= '0;
      rsp_overflow <= 1'b0;
      rsp_miss     <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (trig_valid) begin
            key   <= trig_tag;
            state <= SQ_LOOK;
          end
        end
        SQ_LOOK: begin
          idx    <= '0;
          slot_r <= found_slot;
          if (!found) begin
            rsp_count    <= '0;
            rsp_overflow <= 1'b0;
            rsp_miss     <= 1'b1;
            rsp_done     <= 1'b1;
            state        <= SQ_IDLE;
          end else begin
            rsp_count    <= q_count;
            rsp_overflow <= q_lost;
            rsp_miss     <= 1'b0;
            if (q_count == '0) begin
              rsp_done <= 1'b1;
              state    <= SQ_IDLE;
            end else begin
              state <= SQ_READ;
            end
          end
        end
        SQ_READ: state <= SQ_SHOW;
        SQ_SHOW: begin
          if (out_ready) begin
            if (is_final(idx, rsp_count)) begin
              rsp_done <= 1'b1;
              state    <= SQ_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_READ;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xing_hit_buffer.sv
module xing_hit_buffer #(
  parameter int SLOT_W = 6,
  parameter int HIT_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DW     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bc_strobe,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic             hit_valid,
  input  logic [DW-1:0]    hit_data,
  input  logic             trig_valid,
  input  logic [TAG_W-1:0] trig_tag,
  output logic             trig_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             rsp_done,
  output logic [HIT_W:0]   rsp_count,
  output logic             rsp_overflow,
  output logic             rsp_miss
);

  localparam int SLOTS = 1 << SLOT_W;
  localparam int AW    = SLOT_W + HIT_W;

  logic [SLOT_W-1:0]           wr_slot;
  logic                        slot_open;
  logic                        hit_accept;
  logic                        hit_drop;
  logic                        ram_we;
  logic [AW-1:0]               ram_wa;
  logic [SLOTS-1:0][TAG_W-1:0] tags;
  logic [SLOTS-1:0]            used;
  logic [SLOT_W-1:0]           q_slot;
  logic [HIT_W:0]              q_count;
  logic                        q_lost;
  logic [TAG_W-1:0]            key;
  logic                        found;
  logic [SLOT_W-1:0]           found_slot;
  logic                        ram_re;
  logic [AW-1:0]               ram_ra;
  logic [DW-1:0]               ram_rd;

  xhb_slot_store #(.SLOT_W(SLOT_W), .HIT_W(HIT_W), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .bc_strobe  (bc_strobe),
    .bc_tag     (bc_tag),
    .hit_valid  (hit_valid),
    .wr_slot    (wr_slot),
    .slot_open  (slot_open),
    .hit_accept (hit_accept),
    .hit_drop   (hit_drop),
    .we         (ram_we),
    .wa         (ram_wa),
    .tags       (tags),
    .used       (used),
    .q_slot     (q_slot),
    .q_count    (q_count),
    .q_lost     (q_lost)
  );

  xhb_tag_search #(.SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_search (
    .tags       (tags),
    .used       (used),
    .wr_slot    (wr_slot),
    .key        (key),
    .found      (found),
    .found_slot (found_slot)
  );

  xhb_hit_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk (clk),
    .we  (ram_we),
    .wa  (ram_wa),
    .wd  (hit_data),
    .re  (ram_re),
    .ra  (ram_ra),
    .rd  (ram_rd)
  );

  xhb_readout #(.SLOT_W(SLOT_W), .HIT_W(HIT_W), .TAG_W(TAG_W), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid   (trig_valid),
    .trig_tag     (trig_tag),
    .trig_ready   (trig_ready),
    .key          (key),
    .found        (found),
    .found_slot   (found_slot),
    .q_slot       (q_slot),
    .q_count      (q_count),
    .q_lost       (q_lost),
    .re           (ram_re),
    .ra           (ram_ra),
    .rd           (ram_rd),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last),
    .rsp_done     (rsp_done),
    .rsp_count    (rsp_count),
    .rsp_overflow (rsp_overflow),
    .rsp_miss     (rsp_miss)
  );

endmodule

// File: rtl/xing_hit_buffer_chk.sv
module xing_hit_buffer_chk #(
  parameter int SLOT_W = 6,
  parameter int HIT_W  = 3,
  parameter int DW     = 18,
  localparam int AW    = SLOT_W + HIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bc_strobe,
  input logic              trig_valid,
  input logic              trig_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DW-1:0]     out_data,
  input logic              out_last,
  input logic              rsp_done,
  input logic [HIT_W:0]    rsp_count,
  input logic              rsp_miss,
  input logic [SLOT_W-1:0] wr_slot,
  input logic              slot_open,
  input logic              hit_drop,
  input logic              ram_we,
  input logic [AW-1:0]     ram_wa
);

  logic [HIT_W+1:0]  beats;
  logic [SLOT_W-1:0] nxt_slot;

  assign nxt_slot = wr_slot + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                       beats <= '0;
    else if (trig_valid && trig_ready) beats <= '0;
    else if (out_valid && out_ready)   beats <= beats + 1'b1;
  end

  // R1: nothing is written before the first slot opens
  a_r1_no_write_before_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_open && !bc_strobe) |-> !ram_we);

  // R2: delivered words equal the reported count
  a_r2_beats_match_count: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (beats == {1'b0, rsp_count}));

  // R3: a dropped hit never reaches memory
  a_r3_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_drop |-> !ram_we);

  // R4: a hit coinciding with a strobe lands in word 0 of the next slot
  a_r4_strobe_hit_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_strobe && ram_we) |-> (ram_wa == {nxt_slot, {HIT_W{1'b0}}}));

  // R6: a miss sends nothing
  a_r6_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_miss) |-> (rsp_count == '0 && beats == '0));

  // R8: a stalled word holds still
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8: last marks only an offered word
  a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R11: requests are refused while streaming
  a_r11_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !trig_ready);

endmodule

bind xing_hit_buffer xing_hit_buffer_chk #(.SLOT_W(SLOT_W), .HIT_W(HIT_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bc_strobe  (bc_strobe),
  .trig_valid (trig_valid),
  .trig_ready (trig_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .rsp_done   (rsp_done),
  .rsp_count  (rsp_count),
  .rsp_miss   (rsp_miss),
  .wr_slot    (wr_slot),
  .slot_open  (slot_open),
  .hit_drop   (hit_drop),
  .ram_we     (ram_we),
  .ram_wa     (ram_wa)
);

// File: tb/xing_hit_buffer_bench.sv
module xing_hit_buffer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bc_strobe = 1'b0;
  logic [7:0]  bc_tag = '0;
  logic        hit_valid = 1'b0;
  logic [17:0] hit_data = '0;
  logic        trig_valid = 1'b0;
  logic [7:0]  trig_tag = '0;
  logic        trig_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [17:0] out_data;
  logic        out_last;
  logic        rsp_done;
  logic [3:0]  rsp_count;
  logic        rsp_overflow;
  logic        rsp_miss;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  xing_hit_buffer u_xing_hit_buffer (
    .clk (clk), .rst_n (rst_n), .bc_strobe (bc_strobe), .bc_tag (bc_tag),
    .hit_valid (hit_valid), .hit_data (hit_data), .trig_valid (trig_valid),
    .trig_tag (trig_tag), .trig_ready (trig_ready), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data), .out_last (out_last),
    .rsp_done (rsp_done), .rsp_count (rsp_count), .rsp_overflow (rsp_overflow),
    .rsp_miss (rsp_miss)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] tag_of(input int k);
    return 8'(k * 37 + 5);
  endfunction

  function automatic int hits_of(input int k);
    return k % 10;
  endfunction

  function automatic logic [17:0] word_of(input int k, input int j);
    return {tag_of(k), 4'(j), 6'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Open crossing k with tag t and n hits; the first hit rides with the strobe.
  task automatic put_slot(input int k, input logic [7:0] t, input int n);
    int cycles;
    cycles = (n > 0) ? n : 1;
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      bc_strobe = (j == 0);
      bc_tag    = t;
      hit_valid = (j < n);
      hit_data  = word_of(k, j);
    end
    @(negedge clk);
    bc_strobe = 1'b0;
    hit_valid = 1'b0;
  endtask

  task automatic send_trig(input logic [7:0] t, input string req);
    @(negedge clk);
    chk(trig_ready == 1'b1, req, "trig_ready before request", trig_ready, 1);
    trig_valid = 1'b1;
    trig_tag   = t;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic collect(input int k, input int ec, input bit eovf, input bit emiss,
                         input string req);
    int idx;
    bit done;
    idx  = 0;
    done = 1'b0;
    for (int w = 0; w < 400 && !done; w++) begin
      @(negedge clk);
      out_ready = ((w % 3) != 1);
      if (rsp_done) begin
        chk(rsp_count == 4'(ec), req, "rsp_count", rsp_count, ec);
        chk(rsp_overflow == eovf, req, "rsp_overflow", rsp_overflow, eovf);
        chk(rsp_miss == emiss, req, "rsp_miss", rsp_miss, emiss);
        chk(idx == ec, req, "words delivered", idx, ec);
        done = 1'b1;
      end else if (out_valid && out_ready) begin
        chk(idx < ec, req, "extra word index", idx, ec);
        chk(out_data == word_of(k, idx), req, "out_data", out_data, word_of(k, idx));
        chk(out_last == (idx == ec - 1), req, "out_last", out_last, (idx == ec - 1));
        idx++;
      end
    end
    if (!done) chk(1'b0, req, "response timeout", 0, 1);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    int n;
    logic [17:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(trig_ready == 1'b1, "R1", "trig_ready after reset", trig_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(rsp_done == 1'b0, "R1", "rsp_done after reset", rsp_done, 0);

    // R1: hit before any strobe is discarded; R6: any request misses
    hit_valid = 1'b1;
    hit_data  = 18'h3ffff;
    @(negedge clk);
    hit_valid = 1'b0;
    send_trig(tag_of(0), "R6");
    collect(0, 0, 1'b0, 1'b1, "R6");

    // Fill every slot with 0..9 hits
    for (int k = 0; k < 64; k++) put_slot(k, tag_of(k), hits_of(k));

    // R2 R3 R4 R7: read back every crossing; oldest (k=0) still in window (R5)
    for (int k = 0; k < 64; k++) begin
      n = hits_of(k);
      if (n == 0)     begin send_trig(tag_of(k), "R7"); collect(k, 0, 1'b0, 1'b0, "R7"); end
      else if (n > 8) begin send_trig(tag_of(k), "R3"); collect(k, 8, 1'b1, 1'b0, "R3"); end
      else            begin send_trig(tag_of(k), "R2"); collect(k, n, 1'b0, 1'b0, "R2_R4"); end
    end

    // R5: one more crossing pushes out the oldest
    put_slot(64, tag_of(64), 0);
    send_trig(tag_of(0), "R5");
    collect(0, 0, 1'b0, 1'b1, "R5");
    send_trig(tag_of(1), "R5");
    collect(1, 1, 1'b0, 1'b0, "R5");

    // R7: recycled slot that held a hit returns empty
    put_slot(65, tag_of(65), 0);
    send_trig(tag_of(65), "R7");
    collect(65, 0, 1'b0, 1'b0, "R7");
    send_trig(tag_of(1), "R5");
    collect(1, 0, 1'b0, 1'b1, "R5");

    // R8 R9 R11: stall a readback and keep capturing meanwhile
    send_trig(tag_of(19), "R9");
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b1, "R8", "out_valid while stalled", out_valid, 1);
    chk(trig_ready == 1'b0, "R11", "trig_ready while busy", trig_ready, 0);
    held = out_data;
    chk(held == word_of(19, 0), "R8", "first word while stalled", held, word_of(19, 0));
    trig_valid = 1'b1;
    trig_tag   = tag_of(5);
    repeat (2) @(negedge clk);
    trig_valid = 1'b0;
    put_slot(66, tag_of(13), 2);
    chk(out_data == held, "R8", "out_data held over stall", out_data, held);
    collect(19, 8, 1'b1, 1'b0, "R9");
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      chk(!rsp_done && !out_valid, "R11", "ignored request answered",
          {rsp_done, out_valid}, 0);
    end

    // R10 R9: duplicate tag returns the newer crossing captured during readback
    send_trig(tag_of(13), "R10");
    collect(66, 2, 1'b0, 1'b0, "R10_R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule